// File: doc/BRIEF.md
# Relocatable GPIO and Timer Register Window

This block is a byte-wide memory-mapped peripheral for a 32-bit processor's data bus. It answers a 256-byte register window. The window's start address sits in a base register that the core's control-register file writes. Any byte address is a legal base, and a base of zero switches the whole window off. Addresses are taken modulo 2^32, so a window that runs past the top of the address space wraps to address zero and keeps decoding.

The window holds four things:
- a direction register and a data register for four general-purpose pins;
- a 64-bit free-running timer;
- a 64-bit compare value;
- a pending-status byte for pin-change events.

The block drives a 32-bit pending vector for the core's interrupt logic. The timer-match bit is at position 7 and the pin-change bit is at position 16. Bus reads are combinational: `busRdata` and `busHit` follow the address in the same cycle. Writes take effect at the next rising clock edge.

Top module: `mmio_pin_timer`

## Requirements
- R1: After reset the base register, direction, output latch and timer are zero, and the compare value is all ones. `pinDir`, `pinOut` and `pendVec` are zero, and with the pins held low they stay that way.
- R2: While the base register is zero, no address is claimed (`busHit` = 0), reads return 0 and writes change nothing.
- R3: With a nonzero base B, an address A is claimed exactly when (A − B) mod 2^32 < 256. The offset is that difference, and B needs no alignment.
- R4: Offset 0 is the direction byte. Bits 3:0 set each pin's direction, with 1 meaning output and 0 meaning input, and bits 7:4 always read 0. `pinDir` shows the stored value.
- R5: Offset 1 is the data byte. A write updates the output latch only in the bits of output pins, and `pinOut` shows the latch. A read returns the latch for output pins and, for input pins, the pin level registered one clock earlier.
- R6: Offsets 2 to 9 hold the timer, least significant byte at offset 2. The timer adds 1 every clock. In a cycle that writes a timer byte, that byte takes the written value, the other bytes keep their values, and the timer does not count.
- R7: Offsets 10 to 17 hold the compare value, least significant byte at offset 10, and each byte is written on its own.
- R8: `pendVec` bit 7 is 1 exactly when the timer is greater than or equal to the compare value, both taken as unsigned numbers.
- R9: When an input-configured pin differs from its value registered at the previous edge, `pendVec` bit 16 is 1 from the next edge on. Offset 18 bit 0 reads this bit. Writing a byte with bit 0 set to offset 18 clears it, writing bit 0 as 0 leaves it, and a new change wins over a clear in the same cycle. Changes on output-configured pins are ignored.
- R10: Offsets 19 to 255 read as 0, and writes to them change no register or output.
- R11: All `pendVec` bits other than 7 and 16 are 0, including bit 17, which this block never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csrWe | input | 1 | Write strobe for the window base register |
| csrWdata | input | 32 | New window base address |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte (0 when not claimed) |
| busHit | output | 1 | The access falls inside the window |
| pinIn | input | 4 | Pin levels from the pads |
| pinOut | output | 4 | Output latch to the pads |
| pinDir | output | 4 | Pin directions (1 = output) |
| pendVec | output | 32 | Interrupt pending vector (bit 7 timer, bit 16 pin change) |

## Verification
The bench places the window at an odd base and later at a base where the window crosses address zero. It probes the last claimed byte and the first unclaimed bytes on both sides; a decoder that compared against an unwrapped end address would reject the wrapped half of the window. It loads the timer just below a 32-bit carry and just below the compare value, so that a byte-order mistake, a missing carry or an off-by-one in the greater-or-equal test shows up as a wrong byte or a pending bit that comes a cycle early or late. It writes ones through the data register into input pins and into reserved offsets, toggles output-configured pins, and writes 0 and then 1 to the status bit. A design that let input bits latch, claimed reserved storage, raised the pin pending bit on output pins or cleared it on a zero write would show the error on `pinOut`, `pinDir` or `pendVec`.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int TIMER_BYTES = 8;
  localparam int TIMER_W     = 8 * TIMER_BYTES;
  localparam int WIN_BYTES   = 256;
  localparam int OFF_W       = $clog2(WIN_BYTES);
  localparam int DIR_OFF     = 0;
  localparam int DATA_OFF    = 1;
  localparam int TIM_OFF     = 2;
  localparam int CMP_OFF     = TIM_OFF + TIMER_BYTES;
  localparam int STAT_OFF    = CMP_OFF + TIMER_BYTES;
  localparam int TIMER_PEND_BIT = 7;
  localparam int PIN_PEND_BIT   = 16;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic                   dirWe;
    logic                   dataWe;
    logic [TIMER_BYTES-1:0] timWe;
    logic [TIMER_BYTES-1:0] cmpWe;
    logic                   pendClr;
    logic                   rdSel;
    logic [OFF_W-1:0]       rdOff;
  } strobe_t;
endpackage

// File: rtl/mmio_ctrl.sv
module mmio_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrWdata,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output strobe_t           strb,
  output logic              busHit
);
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] offset;
  logic              winOn;
  logic              wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     baseReg <= '0;
    else if (csrWe) baseReg <= csrWdata;
  end

  // Modular subtraction handles windows that wrap past the top of memory
  assign offset = busAddr - baseReg;
  assign winOn  = (baseReg != '0);
  assign busHit = busValid && winOn && (offset < ADDR_W'(WIN_BYTES));
  assign wr     = busHit && busWrite;

  always_comb begin
    strb         = '0;
    strb.dirWe   = wr && (offset == ADDR_W'(DIR_OFF));
    strb.dataWe  = wr && (offset == ADDR_W'(DATA_OFF));
    for (int i = 0; i < TIMER_BYTES; i++) begin
      strb.timWe[i] = wr && (offset == ADDR_W'(TIM_OFF + i));
      strb.cmpWe[i] = wr && (offset == ADDR_W'(CMP_OFF + i));
    end
    strb.pendClr = wr && (offset == ADDR_W'(STAT_OFF)) && busWdata[0];
    strb.rdSel   = busHit && !busWrite;
    strb.rdOff   = offset[OFF_W-1:0];
  end

  assert_off_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (baseReg == '0) |-> !busHit);

  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.dirWe, strb.dataWe, strb.timWe, strb.cmpWe, strb.pendClr}));
endmodule

// File: rtl/mmio_dp.sv
module mmio_dp
  import mmio_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         strb,
  input  logic [7:0]      busWdata,
  input  logic [PINS-1:0] pinIn,
  output logic [7:0]      busRdata,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinDir,
  output logic            pendTimer,
  output logic            pendPin
);
  localparam int IDX_W = $clog2(TIMER_BYTES);

  logic [PINS-1:0]    dirReg, outReg, pinQ, pinChg;
  logic [TIMER_W-1:0] timer, cmpVal, timNext, cmpNext;
  logic [OFF_W-1:0]   timIdx, cmpIdx;

  assign pinChg = (pinIn ^ pinQ) & ~dirReg;

  always_comb begin
    timNext = timer + 1'b1;
    cmpNext = cmpVal;
    if (|strb.timWe) timNext = timer;
    for (int i = 0; i < TIMER_BYTES; i++) begin
      if (strb.timWe[i]) timNext[8*i +: 8] = busWdata;
      if (strb.cmpWe[i]) cmpNext[8*i +: 8] = busWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg  <= '0;
      outReg  <= '0;
      pinQ    <= '0;
      timer   <= '0;
      cmpVal  <= '1;
      pendPin <= 1'b0;
    end else begin
      pinQ   <= pinIn;
      timer  <= timNext;
      cmpVal <= cmpNext;
      if (strb.dirWe)  dirReg <= busWdata[PINS-1:0];
      if (strb.dataWe) outReg <= (outReg & ~dirReg) | (busWdata[PINS-1:0] & dirReg);
      if (|pinChg)           pendPin <= 1'b1;
      else if (strb.pendClr) pendPin <= 1'b0;
    end
  end

  assign pendTimer = (timer >= cmpVal);
  assign pinOut    = outReg;
  assign pinDir    = dirReg;

  assign timIdx = strb.rdOff - OFF_W'(TIM_OFF);
  assign cmpIdx = strb.rdOff - OFF_W'(CMP_OFF);

  always_comb begin
    busRdata = '0;
    if (strb.rdSel) begin
      if (strb.rdOff == OFF_W'(DIR_OFF))
        busRdata = 8'(dirReg);
      else if (strb.rdOff == OFF_W'(DATA_OFF))
        busRdata = 8'((outReg & dirReg) | (pinQ & ~dirReg));
      else if (strb.rdOff >= OFF_W'(TIM_OFF) && strb.rdOff < OFF_W'(CMP_OFF))
        busRdata = timer[{timIdx[IDX_W-1:0], 3'b000} +: 8];
      else if (strb.rdOff >= OFF_W'(CMP_OFF) && strb.rdOff < OFF_W'(STAT_OFF))
        busRdata = cmpVal[{cmpIdx[IDX_W-1:0], 3'b000} +: 8];
      else if (strb.rdOff == OFF_W'(STAT_OFF))
        busRdata = {7'b0, pendPin};
    end
  end

  assert_dir_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel && strb.rdOff == OFF_W'(DIR_OFF)) |-> (busRdata[7:PINS] == '0));

  assert_input_bits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dataWe |=> (((outReg ^ $past(outReg)) & ~$past(dirReg)) == '0));

  assert_timer_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.timWe == '0) |=> (timer == $past(timer) + 1'b1));

  assert_timer_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pendTimer && strb.timWe == '0 && strb.cmpWe == '0 && timer != '1) |=> pendTimer);

  assert_pin_change_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pinChg) |=> pendPin);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel && strb.rdOff > OFF_W'(STAT_OFF)) |-> (busRdata == 8'h00));
endmodule

// File: rtl/mmio_pin_timer.sv
module mmio_pin_timer
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrWdata,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busHit,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinDir,
  output logic [31:0]       pendVec
);
  strobe_t strb;
  logic    pendTimer, pendPin;

  mmio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csrWe(csrWe), .csrWdata(csrWdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .strb(strb), .busHit(busHit)
  );

  mmio_dp #(.PINS(PINS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWdata(busWdata),
    .pinIn(pinIn), .busRdata(busRdata), .pinOut(pinOut), .pinDir(pinDir),
    .pendTimer(pendTimer), .pendPin(pendPin)
  );

  always_comb begin
    pendVec                 = '0;
    pendVec[TIMER_PEND_BIT] = pendTimer;
    pendVec[PIN_PEND_BIT]   = pendPin;
  end
endmodule

// File: tb/test_mmio_pin_timer.sv
`timescale 1ns/1ps
module test_mmio_pin_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csrWe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        busHit;
  logic [3:0]  pinIn = '0;
  logic [3:0]  pinOut, pinDir;
  logic [31:0] pendVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] base;

  mmio_pin_timer i_mmio_pin_timer (
    .clk(clk), .rst_n(rst_n), .csrWe(csrWe), .csrWdata(csrWdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busHit(busHit),
    .pinIn(pinIn), .pinOut(pinOut), .pinDir(pinDir), .pendVec(pendVec)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setBase(logic [31:0] b);
    @(negedge clk); csrWe = 1'b1; csrWdata = b;
    @(posedge clk);
    @(negedge clk); csrWe = 1'b0;
    base = b;
  endtask

  // One write per call; consecutive calls write on consecutive edges
  task automatic wr(logic [31:0] a, logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); busValid = 1'b0; busWrite = 1'b0;
  endtask

  // Combinational read inside the current low phase
  task automatic rd(logic [31:0] a, output logic [7:0] d, output logic h);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #0.2; d = busRdata; h = busHit;
    busValid = 1'b0;
  endtask

  task automatic rd64(int off, output logic [63:0] v);
    logic [7:0] d; logic h;
    for (int i = 0; i < 8; i++) begin
      rd(base + 32'(off + i), d, h);
      v[8*i +: 8] = d;
    end
  endtask

  task automatic wr64(int off, logic [63:0] v);
    for (int i = 0; i < 8; i++) wr(base + 32'(off + i), v[8*i +: 8]);
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] d; logic h;
    @(negedge clk);
    check("R1 pinDir", 64'(pinDir), 0);
    check("R1 pinOut", 64'(pinOut), 0);
    check("R1 pendVec", 64'(pendVec), 0);
    rd(32'h0000_0000, d, h);
    check("R2 hit at base zero", 64'(h), 0);
    check("R2 read at base zero", 64'(d), 0);
  endtask

  task automatic t_disabled();
    wr(32'h0000_0000, 8'hFF);
    wr(32'h0000_0001, 8'hFF);
    idle();
    check("R2 write ignored dir", 64'(pinDir), 0);
    check("R2 write ignored out", 64'(pinOut), 0);
  endtask

  task automatic t_dir();
    logic [7:0] d; logic h;
    wr(base, 8'hFF); idle();
    check("R4 pinDir all out", 64'(pinDir), 64'hF);
    rd(base, d, h);
    check("R3 hit at base", 64'(h), 1);
    check("R4 dir read upper zero", 64'(d), 64'h0F);
    wr(base, 8'hA5); idle();
    check("R4 pinDir 0101", 64'(pinDir), 64'h5);
  endtask

  task automatic t_data();
    logic [7:0] d; logic h;
    wr(base + 1, 8'hFF); idle();
    check("R5 only output bits latch", 64'(pinOut), 64'h5);
    pinIn = 4'hA;
    @(negedge clk);
    rd(base + 1, d, h);
    check("R5 data read mixes latch and pins", 64'(d), 64'h0F);
    wr(base + 1, 8'h00); idle();
    check("R5 output bits clear", 64'(pinOut), 64'h0);
    rd(base + 1, d, h);
    check("R5 input bits still show pins", 64'(d), 64'h0A);
  endtask

  task automatic t_pinPend();
    logic [7:0] d; logic h;
    wr(base + 18, 8'h01); idle();
    check("R9 cleared", 64'(pendVec[16]), 0);
    rd(base + 18, d, h);
    check("R9 status read clear", 64'(d), 0);
    pinIn = 4'h8;               // bit 1 input goes low
    @(negedge clk);
    check("R9 set on input change", 64'(pendVec[16]), 1);
    rd(base + 18, d, h);
    check("R9 status read set", 64'(d), 1);
    wr(base + 18, 8'hFE); idle();
    check("R9 zero write keeps", 64'(pendVec[16]), 1);
    wr(base + 18, 8'h01); idle();
    check("R9 one write clears", 64'(pendVec[16]), 0);
    pinIn = 4'h9;               // bit 0 is an output pin
    @(negedge clk); @(negedge clk);
    check("R9 output pin change ignored", 64'(pendVec[16]), 0);
    check("R11 other bits zero", 64'(pendVec & ~32'h0001_0080), 0);
  endtask

  task automatic t_timer();
    logic [63:0] v;
    logic [63:0] c = 64'h0000_0001_0000_0010;
    @(negedge clk);
    check("R8 no pend with max compare", 64'(pendVec[7]), 0);
    wr64(2, 64'h0000_0000_FFFF_FFFE);
    rd64(2, v);
    check("R6 timer loaded", v, 64'h0000_0000_FFFF_FFFE);
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd64(2, v);
    check("R6 timer carry", v, 64'h0000_0001_0000_0001);
    wr64(10, c);
    rd64(10, v);
    check("R7 compare readback", v, c);
    wr64(2, c - 3);
    check("R8 below compare", 64'(pendVec[7]), 0);
    @(negedge clk); @(negedge clk);
    check("R8 one below compare", 64'(pendVec[7]), 0);
    @(negedge clk);
    check("R8 equal sets pend", 64'(pendVec[7]), 1);
    @(negedge clk);
    check("R8 above keeps pend", 64'(pendVec[7]), 1);
    wr(base + 17, 8'h02); idle();
    check("R7 single byte write drops pend", 64'(pendVec[7]), 0);
    rd64(10, v);
    check("R7 compare byte7 only", v, 64'h0200_0001_0000_0010);
    check("R11 bit17 zero", 64'(pendVec[17]), 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d; logic h;
    wr(base + 19, 8'hFF);
    wr(base + 255, 8'hFF);
    idle();
    check("R10 reserved write dir", 64'(pinDir), 64'h5);
    check("R10 reserved write out", 64'(pinOut), 64'h0);
    rd(base + 19, d, h);
    check("R10 reserved read 19", 64'(d), 0);
    rd(base + 255, d, h);
    check("R10 reserved read 255 hit", 64'({h, d}), 64'h100);
    rd(base + 256, d, h);
    check("R3 past end not claimed", 64'(h), 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d; logic h;
    setBase(32'hFFFF_FF80);
    rd(32'h0000_007F, d, h);
    check("R3 wrapped last byte claimed", 64'(h), 1);
    rd(32'h0000_0080, d, h);
    check("R3 wrapped end not claimed", 64'(h), 0);
    rd(32'hFFFF_FF7F, d, h);
    check("R3 below base not claimed", 64'(h), 0);
    rd(32'hFFFF_FF80, d, h);
    check("R3 wrapped base reads dir", 64'(d), 64'h05);
    wr(32'hFFFF_FF80, 8'h0F); idle();
    check("R3 write through wrapped base", 64'(pinDir), 64'hF);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_disabled();
    setBase(32'h0000_1003);
    t_dir();
    t_data();
    t_pinPend();
    t_timer();
    t_reserved();
    t_wrap();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule